// File: doc/BRIEF.md
# Decode-Stage Static Branch Direction Predictor

This block makes fetch-steering decisions for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) that has no branch delay slots. In decode it looks at the class of the instruction, its branch displacement and its PC. A conditional branch whose displacement is negative is guessed taken, which usually means a loop-closing branch. A conditional branch with a zero or positive displacement is guessed not taken. An unconditional direct branch always steers fetch. A taken guess sends fetch to `pc + displacement` in the next cycle and squashes the fall-through instruction that was fetched behind the branch. That costs one bubble.

The guess for each conditional branch is held for one cycle, so that when the branch reaches execute it can be compared with the real outcome supplied by the execute stage. On a wrong guess, fetch is steered to the correct address: the resolved target, or the address after the branch. Both younger instructions, in fetch and in decode, are squashed, which costs two cycles. A correction from execute takes priority over any decode-stage steer in the same cycle.

Top module: `bwd_taken_predictor`

## Requirements
- R1: After reset, and with no branch in decode, `fetch_redirect`, `flush_if` and `flush_id` are low. No correction is made in the first cycle after reset.
- R2: When `id_kind` is 2'b01 (conditional) and bit DISP_W-1 of `id_disp` is 1, and no correction is active, `fetch_redirect` and `flush_if` are high in that same cycle, `flush_id` is low, and `redirect_pc` equals `id_pc` plus the sign-extended displacement, modulo 2^XLEN.
- R3: When `id_kind` is 2'b01 and bit DISP_W-1 of `id_disp` is 0, no redirect and no flush is raised in that cycle.
- R4: When `id_kind` is 2'b10 (unconditional direct), fetch is redirected to `id_pc` plus the sign-extended displacement for either sign, with `flush_if` high. The branch is not checked in execute: `ex_taken` is ignored in the following cycle.
- R5: When `id_kind` is 2'b00 or 2'b11 (not a branch), there is no redirect, and `ex_taken` is ignored in the following cycle.
- R6: One cycle after a conditional branch guessed taken, if `ex_taken` is 0, `fetch_redirect`, `flush_if` and `flush_id` are high and `redirect_pc` is the branch PC plus INSN_BYTES.
- R7: One cycle after a conditional branch guessed not taken, if `ex_taken` is 1, `fetch_redirect`, `flush_if` and `flush_id` are high and `redirect_pc` equals `ex_target`.
- R8: One cycle after a conditional branch, if `ex_taken` matches the guess, no correction is made and `flush_id` stays low.
- R9: When an execute correction and a decode redirect fall in the same cycle, `redirect_pc` carries the correction address.
- R10: A conditional branch that sits in decode during a correction is squashed, so its `ex_taken` in the next cycle causes no correction.
- R11: Only the top bit of the displacement sets the direction. The largest positive value is guessed not taken, and the most negative value (top bit alone set) is guessed taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_kind | input | 2 | Class of instruction in decode: 00 other, 01 conditional, 10 unconditional direct, 11 other |
| id_disp | input | DISP_W | Two's-complement byte displacement of the decode instruction |
| id_pc | input | XLEN | PC of the decode instruction |
| ex_taken | input | 1 | Resolved outcome of the instruction in execute |
| ex_target | input | XLEN | Resolved target of the instruction in execute |
| fetch_redirect | output | 1 | Steer fetch to `redirect_pc` next cycle |
| redirect_pc | output | XLEN | Address fetch is steered to |
| flush_if | output | 1 | Squash the instruction now in fetch |
| flush_id | output | 1 | Squash the instruction now in decode |

## Verification
The bench uses the defaults XLEN=32, DISP_W=13 and INSN_BYTES=4. The narrow 13-bit displacement brings both extremes, -4096 and +4095, within reach, which exercises the sign-only direction rule at its edges. The 32-bit PC lets a target just past the top of the address space wrap around to a low address. The bench also runs the four guess/outcome pairings back to back, and it places branches in decode during corrections to reach the override and squash cases.

// File: rtl/bwd_taken_predictor.sv
module bwd_taken_predictor #(
  parameter int XLEN       = 32,
  parameter int DISP_W     = 13,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        id_kind,
  input  logic [DISP_W-1:0] id_disp,
  input  logic [XLEN-1:0]   id_pc,
  input  logic              ex_taken,
  input  logic [XLEN-1:0]   ex_target,
  output logic              fetch_redirect,
  output logic [XLEN-1:0]   redirect_pc,
  output logic              flush_if,
  output logic              flush_id
);
  localparam int          EXT    = XLEN - DISP_W;
  localparam logic [1:0]  K_COND = 2'b01;
  localparam logic [1:0]  K_JUMP = 2'b10;
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic            is_cond, is_jump, guess_taken, id_steer, ex_fix;
  logic [XLEN-1:0] id_target, ex_fix_pc;
  logic            ex_live, ex_guess;
  logic [XLEN-1:0] ex_pc;

  assign is_cond     = id_kind == K_COND;
  assign is_jump     = id_kind == K_JUMP;
  assign guess_taken = is_cond && id_disp[DISP_W-1];
  assign id_target   = id_pc + {{EXT{id_disp[DISP_W-1]}}, id_disp};
  assign id_steer    = guess_taken || is_jump;

  assign ex_fix    = ex_live && (ex_taken != ex_guess);
  assign ex_fix_pc = ex_taken ? ex_target : ex_pc + STEP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_live  <= 1'b0;
      ex_guess <= 1'b0;
      ex_pc    <= '0;
    end else begin
      ex_live  <= is_cond && !ex_fix;
      ex_guess <= guess_taken;
      ex_pc    <= id_pc;
    end
  end

  assign fetch_redirect = ex_fix || id_steer;
  assign redirect_pc    = ex_fix ? ex_fix_pc : id_target;
  assign flush_if       = fetch_redirect;
  assign flush_id       = ex_fix;

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !flush_id);
  p_fwd_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (id_kind == K_COND && !id_disp[DISP_W-1] && !flush_id) |-> !fetch_redirect);
  p_jump_steers_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (id_kind == K_JUMP) |-> (fetch_redirect && flush_if));
  p_other_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (id_kind != K_COND && id_kind != K_JUMP && !flush_id) |-> !fetch_redirect);
  p_fix_flushes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_id |-> (fetch_redirect && flush_if));
  p_no_fix_twice_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_id |=> !flush_id);
endmodule

// File: tb/bwd_taken_predictor_bench.sv
`timescale 1ns/1ps
module bwd_taken_predictor_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  id_kind = 0;
  logic [12:0] id_disp = 0;
  logic [31:0] id_pc = 0;
  logic        ex_taken = 0;
  logic [31:0] ex_target = 0;
  logic        fetch_redirect, flush_if, flush_id;
  logic [31:0] redirect_pc;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_live = 0, m_guess = 0;
  longint m_pc = 0;

  always #2.5 clk = ~clk;

  bwd_taken_predictor u_bwd_taken_predictor (
    .clk(clk), .rst_n(rst_n), .id_kind(id_kind), .id_disp(id_disp), .id_pc(id_pc),
    .ex_taken(ex_taken), .ex_target(ex_target), .fetch_redirect(fetch_redirect),
    .redirect_pc(redirect_pc), .flush_if(flush_if), .flush_id(flush_id));

  task automatic step(input logic [1:0] k, input int d, input longint pc,
                      input bit t, input longint tgt, input string req);
    bit fix, steer, e_red, e_fid;
    longint e_pc;
    @(negedge clk);
    id_kind = k; id_disp = 13'(d); id_pc = 32'(pc); ex_taken = t; ex_target = 32'(tgt);
    #1;
    fix   = m_live && (t != m_guess);
    steer = (k == 2'b01 && d < 0) || k == 2'b10;
    e_red = fix || steer;
    e_fid = fix;
    if (fix) e_pc = t ? (tgt & 64'hFFFF_FFFF) : ((m_pc + 4) & 64'hFFFF_FFFF);
    else     e_pc = (pc + d) & 64'hFFFF_FFFF;
    checks++;
    if (fetch_redirect !== e_red || flush_if !== e_red || flush_id !== e_fid ||
        (e_red && redirect_pc !== 32'(e_pc))) begin
      errors++;
      $display("FAIL %s: red=%0b fif=%0b fid=%0b pc=%h expected red=%0b fif=%0b fid=%0b pc=%h",
               req, fetch_redirect, flush_if, flush_id, redirect_pc, e_red, e_red, e_fid, 32'(e_pc));
    end
    m_live  = (k == 2'b01) && !fix;
    m_guess = d < 0;
    m_pc    = pc;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    step(2'b00, 0, 32'h100, 1, 32'h900, "R1");
    step(2'b00, 0, 32'h104, 1, 32'h900, "R1");
    // R2 backward conditional, then correct taken outcome (R8)
    step(2'b01, -16, 32'h200, 0, 0, "R2");
    step(2'b00, 0, 32'h1F0, 1, 32'h1F0, "R8");
    // R3 forward conditional, correct not-taken (R8)
    step(2'b01, 40, 32'h300, 0, 0, "R3");
    step(2'b00, 0, 32'h304, 0, 0, "R8");
    // R6 guessed taken, actually not taken
    step(2'b01, -8, 32'h400, 0, 0, "R2");
    step(2'b00, 0, 32'h3F8, 0, 0, "R6");
    // R7 guessed not taken, actually taken
    step(2'b01, 12, 32'h500, 0, 0, "R3");
    step(2'b00, 0, 32'h504, 1, 32'h50C, "R7");
    // R4 unconditional both signs, ex_taken ignored afterwards
    step(2'b10, 64, 32'h600, 0, 0, "R4");
    step(2'b10, -64, 32'h640, 1, 32'hABC, "R4");
    step(2'b00, 0, 32'h600, 1, 32'hDEF, "R4");
    // R5 other kinds ignored
    step(2'b11, -4, 32'h700, 0, 0, "R5");
    step(2'b00, -4, 32'h704, 1, 32'h123, "R5");
    step(2'b00, 0, 32'h708, 0, 0, "R5");
    // R9 correction overrides a decode steer; R10 squashed branch ignored
    step(2'b01, 8, 32'h800, 0, 0, "R3");
    step(2'b01, -32, 32'h804, 1, 32'h808, "R9");
    step(2'b00, 0, 32'h808, 0, 0, "R10");
    step(2'b01, 8, 32'h900, 0, 0, "R3");
    step(2'b10, 100, 32'h904, 1, 32'h908, "R9");
    // R11 extremes of displacement
    step(2'b01, 4095, 32'hA00, 0, 0, "R11");
    step(2'b01, -4096, 32'h3000, 0, 0, "R11");
    step(2'b00, 0, 32'h2000, 1, 32'h2000, "R11");
    // R2 wrap past top of address space, then mispredict with ex fix (R6)
    step(2'b01, -4, 32'h2, 0, 0, "R2");
    step(2'b00, 0, 32'hFFFF_FFFE, 0, 0, "R6");
    step(2'b10, 16, 32'hFFFF_FFF8, 0, 0, "R4");
    step(2'b00, 0, 32'h8, 0, 0, "R1");
    finish_run();
  end
endmodule